// File: doc/BRIEF.md
# Machine Status Word Controller

This block keeps a four-bit machine status word for a processor core and rules on whether each coprocessor-related instruction must be stopped with the coprocessor-not-available fault, vector 7. The decode stage tells it the class of each instruction as it issues, using a valid strobe. The class is a coprocessor escape, a WAIT, or anything else. The block answers one cycle later with a fault pulse. The pulse carries the vector number. Software changes the word through a load command. A separate command clears only the task-switched bit. The task-switch logic sets that bit with a strobe. The current word is always readable on a plain store port.

Bit order, from the least significant bit: bit 0 is protection enable (PE), bit 1 is coprocessor monitoring (MP), bit 2 is coprocessor emulation (EM), and bit 3 is task switched (TS). PE drives the protected-mode indicator and stays set until reset. The load command is a data stream with a valid strobe only. The block takes every load in the cycle its valid is high and never applies back-pressure, so the sender needs no ready signal. All other pins are plain levels or single-cycle strobes.

Top module: `msw_ctrl`

## Requirements
- R1: After reset the word is 0000, `prot_mode` is 0, `fault_valid` is 0 and `fault_vector` is 0.
- R2: A load (`ld_valid`=1) writes `ld_data[3]`→TS, `ld_data[2]`→EM and `ld_data[1]`→MP. The new value shows on `msw_q` after the next rising edge.
- R3: A load with `ld_data[0]`=1 sets PE. A load with `ld_data[0]`=0 leaves PE as it was. Only reset clears PE. `prot_mode` always equals PE.
- R4: A valid instruction of class escape (`ins_cls`=2'b01) raises a fault when EM or TS is set.
- R5: A valid instruction of class WAIT (`ins_cls`=2'b10) raises a fault only when both MP and TS are set. EM has no effect on WAIT.
- R6: Class 2'b00 and class 2'b11 never fault. No fault is raised in a cycle where `ins_valid` is 0.
- R7: `task_sw` sets TS and `clr_ts` clears TS. In the same cycle, `task_sw` takes priority over `clr_ts`, and `clr_ts` takes priority over a load's TS bit.
- R8: A fault appears as `fault_valid`=1 for exactly the cycle after the instruction's edge, with `fault_vector`=7. While `fault_valid` is 0, `fault_vector` is 0.
- R9: The fault decision uses the word as it stood before any load, clear or task-switch strobe given in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Load-word command |
| ld_data | input | 4 | Word value to load |
| clr_ts | input | 1 | Clear the task-switched bit |
| task_sw | input | 1 | Task-switch strobe, sets the task-switched bit |
| ins_valid | input | 1 | Instruction-class strobe |
| ins_cls | input | 2 | 00 other, 01 escape, 10 WAIT, 11 other |
| msw_q | output | 4 | Current word (store-word read port) |
| prot_mode | output | 1 | Protected-mode indicator (PE) |
| fault_valid | output | 1 | Coprocessor-not-available fault pulse |
| fault_vector | output | 8 | Fault vector number, 7 during a pulse |

## Verification
A wrong bit in the word shows on `msw_q` on the edge after the command that caused it. The error is therefore visible one cycle later, even before any instruction depends on it. A lost or wrongly cleared PE appears at once on `prot_mode`. A wrong EM, MP or TS value appears only when an escape or WAIT is issued against it, as a missing or extra fault pulse one cycle after that instruction. For this reason the stimulus issues both classes under every combination of those bits. It also issues instructions in the same cycle as updates, to show which word value the decision used.

// File: rtl/msw_pkg.sv
package msw_pkg;
  localparam int MSW_W = 4;
  localparam int PE_B  = 0;
  localparam int MP_B  = 1;
  localparam int EM_B  = 2;
  localparam int TS_B  = 3;

  typedef enum logic [1:0] {
    CLS_OTHER = 2'b00,
    CLS_ESC   = 2'b01,
    CLS_WAIT  = 2'b10,
    CLS_RSVD  = 2'b11
  } ins_cls_e;

  localparam int NM_FAULT_NUM = 7;
endpackage

// File: rtl/msw_state.sv
module msw_state
  import msw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_valid,
  input  logic [MSW_W-1:0] ld_data,
  input  logic             clr_ts,
  input  logic             task_sw,
  output logic [MSW_W-1:0] msw
);
  logic [MSW_W-1:0] msw_nxt;

  always_comb begin
    msw_nxt = msw;
    if (ld_valid) begin
      msw_nxt = ld_data;
      // protection enable only accumulates
      msw_nxt[PE_B] = msw[PE_B] | ld_data[PE_B];
    end
    if (clr_ts)  msw_nxt[TS_B] = 1'b0;
    if (task_sw) msw_nxt[TS_B] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) msw <= '0;
    else        msw <= msw_nxt;
  end
endmodule

// File: rtl/msw_fault.sv
module msw_fault
  import msw_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins_valid,
  input  logic [1:0]       ins_cls,
  input  logic             mp,
  input  logic             em,
  input  logic             ts,
  output logic             fault_valid,
  output logic [VEC_W-1:0] fault_vector
);
  localparam logic [VEC_W-1:0] FVEC = VEC_W'(NM_FAULT_NUM);

  ins_cls_e cls;
  logic     hit;

  always_comb begin
    cls = ins_cls_e'(ins_cls);
    unique case (cls)
      CLS_ESC:  hit = em | ts;
      CLS_WAIT: hit = mp & ts;
      default:  hit = 1'b0;
    endcase
    hit = hit & ins_valid;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fault_valid  <= 1'b0;
      fault_vector <= '0;
    end else begin
      fault_valid  <= hit;
      fault_vector <= hit ? FVEC : '0;
    end
  end
endmodule

// File: rtl/msw_ctrl.sv
module msw_ctrl
  import msw_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_valid,
  input  logic [3:0]       ld_data,
  input  logic             clr_ts,
  input  logic             task_sw,
  input  logic             ins_valid,
  input  logic [1:0]       ins_cls,
  output logic [3:0]       msw_q,
  output logic             prot_mode,
  output logic             fault_valid,
  output logic [VEC_W-1:0] fault_vector
);
  logic [MSW_W-1:0] msw;

  msw_state u_state (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_valid (ld_valid),
    .ld_data  (ld_data),
    .clr_ts   (clr_ts),
    .task_sw  (task_sw),
    .msw      (msw)
  );

  msw_fault #(.VEC_W(VEC_W)) u_fault (
    .clk          (clk),
    .rst_n        (rst_n),
    .ins_valid    (ins_valid),
    .ins_cls      (ins_cls),
    .mp           (msw[MP_B]),
    .em           (msw[EM_B]),
    .ts           (msw[TS_B]),
    .fault_valid  (fault_valid),
    .fault_vector (fault_vector)
  );

  assign msw_q     = msw;
  assign prot_mode = msw[PE_B];
endmodule

// File: rtl/msw_ctrl_chk.sv
module msw_ctrl_chk #(
  parameter int VEC_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ld_valid,
  input logic [3:0]       ld_data,
  input logic             clr_ts,
  input logic             task_sw,
  input logic             ins_valid,
  input logic [1:0]       ins_cls,
  input logic [3:0]       msw_q,
  input logic             prot_mode,
  input logic             fault_valid,
  input logic [VEC_W-1:0] fault_vector
);
  // R3
  pe_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msw_q[0] |=> msw_q[0]);

  // R3
  prot_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prot_mode == msw_q[0]);

  // R4
  esc_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && ins_cls == 2'b01 && (msw_q[2] || msw_q[3])) |=> fault_valid);

  // R5
  wait_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && ins_cls == 2'b10 && !(msw_q[1] && msw_q[3])) |=> !fault_valid);

  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ins_valid || ins_cls[0] == ins_cls[1]) |=> !fault_valid);

  // R7
  tsw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    task_sw |=> msw_q[3]);

  // R7
  clr_ts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ts && !task_sw) |=> !msw_q[3]);

  // R8
  vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_vector == (fault_valid ? VEC_W'(7) : '0));

  // R2
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && !clr_ts && !task_sw) |=> msw_q[3:1] == $past(ld_data[3:1]));
endmodule

bind msw_ctrl msw_ctrl_chk #(.VEC_W(VEC_W)) u_chk (.*);

// File: tb/sim_msw_ctrl.sv
`timescale 1ns/1ps
module sim_msw_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ld_valid, clr_ts, task_sw, ins_valid;
  logic [3:0] ld_data;
  logic [1:0] ins_cls;
  logic [3:0] msw_q;
  logic       prot_mode, fault_valid;
  logic [7:0] fault_vector;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  msw_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_data(ld_data),
    .clr_ts(clr_ts), .task_sw(task_sw), .ins_valid(ins_valid), .ins_cls(ins_cls),
    .msw_q(msw_q), .prot_mode(prot_mode), .fault_valid(fault_valid),
    .fault_vector(fault_vector)
  );

  // [14] ld [13:10] ld_data [9] task_sw [8] clr_ts [7] ins_valid
  // [6:5] class [4:1] expected word [0] expected fault
  localparam int NV = 20;
  localparam logic [14:0] VEC [NV] = '{
    {1'b0,4'b0000,1'b0,1'b0,1'b1,2'b01,4'b0000,1'b0}, // R4 escape, no bits
    {1'b0,4'b0000,1'b0,1'b0,1'b1,2'b10,4'b0000,1'b0}, // R5 wait, no bits
    {1'b1,4'b0100,1'b0,1'b0,1'b0,2'b00,4'b0100,1'b0}, // R2 load EM
    {1'b0,4'b0000,1'b0,1'b0,1'b1,2'b01,4'b0100,1'b1}, // R4 escape with EM
    {1'b0,4'b0000,1'b0,1'b0,1'b1,2'b10,4'b0100,1'b0}, // R5 EM ignored
    {1'b1,4'b0010,1'b0,1'b0,1'b0,2'b00,4'b0010,1'b0}, // R2 load MP
    {1'b0,4'b0000,1'b0,1'b0,1'b1,2'b10,4'b0010,1'b0}, // R5 MP alone
    {1'b0,4'b0000,1'b1,1'b0,1'b0,2'b00,4'b1010,1'b0}, // R7 task switch
    {1'b0,4'b0000,1'b0,1'b0,1'b1,2'b10,4'b1010,1'b1}, // R5 MP and TS
    {1'b0,4'b0000,1'b0,1'b0,1'b1,2'b00,4'b1010,1'b0}, // R6 class 00
    {1'b0,4'b0000,1'b0,1'b0,1'b1,2'b11,4'b1010,1'b0}, // R6 class 11
    {1'b0,4'b0000,1'b0,1'b0,1'b0,2'b01,4'b1010,1'b0}, // R6 not valid
    {1'b0,4'b0000,1'b0,1'b1,1'b1,2'b01,4'b0010,1'b1}, // R9 clear with escape
    {1'b0,4'b0000,1'b0,1'b0,1'b1,2'b01,4'b0010,1'b0}, // R4 after clear
    {1'b1,4'b0001,1'b0,1'b0,1'b0,2'b00,4'b0001,1'b0}, // R3 set PE
    {1'b1,4'b1110,1'b0,1'b0,1'b0,2'b00,4'b1111,1'b0}, // R3 PE kept
    {1'b1,4'b0000,1'b0,1'b0,1'b0,2'b00,4'b0001,1'b0}, // R3 PE kept on zero
    {1'b1,4'b0000,1'b1,1'b1,1'b0,2'b00,4'b1001,1'b0}, // R7 task_sw wins
    {1'b1,4'b1000,1'b0,1'b1,1'b0,2'b00,4'b0001,1'b0}, // R7 clear beats load
    {1'b1,4'b0100,1'b0,1'b0,1'b1,2'b01,4'b0101,1'b0}  // R9 load with escape
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle();
    ld_valid = 0; ld_data = 0; clr_ts = 0; task_sw = 0; ins_valid = 0; ins_cls = 0;
  endtask

  initial begin
    repeat (10000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1 word", msw_q, 0);
    chk("R1 prot", prot_mode, 0);
    chk("R1 fault", fault_valid, 0);
    chk("R1 vector", fault_vector, 0);

    for (int i = 0; i < NV; i++) begin
      ld_valid  = VEC[i][14];
      ld_data   = VEC[i][13:10];
      task_sw   = VEC[i][9];
      clr_ts    = VEC[i][8];
      ins_valid = VEC[i][7];
      ins_cls   = VEC[i][6:5];
      @(negedge clk);
      chk("R2/R7 word", msw_q, VEC[i][4:1]);
      chk("R3 prot", prot_mode, VEC[i][1]);
      chk("R4/R5/R6 fault", fault_valid, VEC[i][0]);
      chk("R8 vector", fault_vector, VEC[i][0] ? 7 : 0);
    end

    // R8: pulse lasts one cycle only
    idle();
    @(negedge clk);
    chk("R8 pulse end", fault_valid, 0);

    // R8: back-to-back faults give back-to-back pulses; word now 0101
    ins_valid = 1; ins_cls = 2'b01;
    @(negedge clk);
    chk("R8 first", fault_valid, 1);
    @(negedge clk);
    chk("R8 second", fault_valid, 1);
    chk("R8 second vector", fault_vector, 7);
    idle();
    @(negedge clk);
    chk("R8 drop", fault_valid, 0);

    // R1/R3: only reset clears PE
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    chk("R1 word after reset", msw_q, 0);
    chk("R3 prot after reset", prot_mode, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule